// File: doc/BRIEF.md
# Sync Event Interrupt Controller

This block collects seven sync-monitoring events into sticky flags and merges them into one active-low interrupt request for a microcontroller. The events cover presence change, polarity change and frequency change for both horizontal and vertical sync, plus a per-frame vertical sync event. Each frequency-change flag is also raised when the matching measurement counter overflows. The logic that detects these events is outside this block. Each event arrives here as a single-cycle pulse.

Every flag has its own enable bit. Enables decide only whether a pending flag pulls the interrupt low. They never prevent a flag from being recorded. Software reads the flags, handles them, and clears each one by writing 0 to its bit. Writing 1 to a bit leaves that flag as it is, so software can clear one flag without a read-modify-write race on the others.

Flag bit order, used by the event input, the write data and the readback: bit 0 horizontal presence, bit 1 vertical presence, bit 2 horizontal polarity, bit 3 vertical polarity, bit 4 horizontal frequency, bit 5 vertical frequency, bit 6 vertical sync event.

Top module: `sync_event_irq_ctrl`

## Requirements
- R1: After reset, all flags are 0, all enable bits are 0, and `irq_n` is 1.
- R2: An `evt_pulse` bit that is 1 at a rising clock edge sets the flag at the same bit position. The flag appears on `flag_q_o`, and on `reg_rdata` when `reg_sel`=0, right after that edge.
- R3: A set flag stays set across any number of cycles until a clearing write reaches it.
- R4: A write with `reg_wr`=1 and `reg_sel`=0 clears every flag whose `reg_wdata` bit is 0. Flags whose `reg_wdata` bit is 1 keep their value.
- R5: If an event pulse and a clearing write hit the same flag in the same cycle, the flag is 1 after that edge.
- R6: `ovf_pulse` bit 0 sets flag bit 4 (horizontal frequency), and `ovf_pulse` bit 1 sets flag bit 5 (vertical frequency), in the same way an event does.
- R7: A write with `reg_wr`=1 and `reg_sel`=1 loads the enable bits from `reg_wdata`. The enables read back on `reg_rdata` when `reg_sel`=1. Enable bits never stop a flag from being set.
- R8: `irq_n` is a registered level. It is 0 in the cycle after an edge at which some flag and its enable bit were both 1. Otherwise it is 1.
- R9: A write to the enable register leaves the flags unchanged. A write to the flag register leaves the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 7 | Single-cycle event pulses, one per flag |
| ovf_pulse | input | 2 | Counter overflow pulses: bit 0 horizontal, bit 1 vertical |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata | input | 7 | Write data |
| reg_rdata | output | 7 | Readback of the selected register |
| flag_q_o | output | 7 | Current flag vector |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag can be set by an event and cleared by a write in the same cycle. The bench provokes this by pulsing the vertical frequency event in the very cycle that an all-zero word is written to the flag register. It then checks that only that flag survives the clear. A second collision is an overflow pulse and an ordinary event landing on different flags in one cycle. Both flags must be recorded. The interrupt output is judged one edge later than the flags, which confirms its registered lag.

// File: rtl/sei_pkg.sv
package sei_pkg;
    localparam int unsigned SEI_NUM_FLAGS = 7;
    localparam int unsigned SEI_IDX_HPRES = 0;
    localparam int unsigned SEI_IDX_VPRES = 1;
    localparam int unsigned SEI_IDX_HPOL  = 2;
    localparam int unsigned SEI_IDX_VPOL  = 3;
    localparam int unsigned SEI_IDX_HFREQ = 4;
    localparam int unsigned SEI_IDX_VFREQ = 5;
    localparam int unsigned SEI_IDX_VEVT  = 6;

    typedef enum logic {
        SEI_SEL_FLAGS  = 1'b0,
        SEI_SEL_ENABLE = 1'b1
    } sei_sel_e;

    typedef struct packed {
        logic pending;
    } sei_flag_state_t;

    typedef struct packed {
        logic req_n;
    } sei_irq_state_t;
endpackage

// File: rtl/sei_flag_bit.sv
module sei_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    import sei_pkg::*;

    sei_flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.pending = 1'b0;
        end
        if (set_i) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.pending;

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R5: a set wins over a clear in the same cycle
    p_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> flag_o);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/sei_enable_reg.sv
module sei_enable_reg #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] en_o
);
    logic [WIDTH-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (load_i) begin
            en_d = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_o = en_q;

    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(en_o));
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (en_o == $past(data_i)));
endmodule

// File: rtl/sei_irq_drive.sv
module sei_irq_drive #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] flags_i,
    input  logic [WIDTH-1:0] en_i,
    output logic             irq_n_o
);
    import sei_pkg::*;

    sei_irq_state_t st_d, st_q;
    logic [WIDTH-1:0] armed;

    always_comb begin
        armed = flags_i & en_i;
        st_d.req_n = ~(|armed);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.req_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n_o = st_q.req_n;

    p_assert_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & en_i) != '0) |=> !irq_n_o);
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & en_i) == '0) |=> irq_n_o);
endmodule

// File: rtl/sync_event_irq_ctrl.sv
module sync_event_irq_ctrl #(
    parameter int unsigned N_FLAGS = sei_pkg::SEI_NUM_FLAGS,
    parameter int unsigned N_OVF   = 2,
    parameter int unsigned HF_IDX  = sei_pkg::SEI_IDX_HFREQ,
    parameter int unsigned VF_IDX  = sei_pkg::SEI_IDX_VFREQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] evt_pulse,
    input  logic [N_OVF-1:0]   ovf_pulse,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [N_FLAGS-1:0] reg_wdata,
    output logic [N_FLAGS-1:0] reg_rdata,
    output logic [N_FLAGS-1:0] flag_q_o,
    output logic               irq_n
);
    import sei_pkg::*;

    localparam logic [N_FLAGS-1:0] HF_MASK = N_FLAGS'(1) << HF_IDX;
    localparam logic [N_FLAGS-1:0] VF_MASK = N_FLAGS'(1) << VF_IDX;

    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] clr_vec;
    logic [N_FLAGS-1:0] flags;
    logic [N_FLAGS-1:0] enables;
    logic               flag_wr;
    logic               en_wr;

    always_comb begin
        flag_wr = reg_wr && (sei_sel_e'(reg_sel) == SEI_SEL_FLAGS);
        en_wr   = reg_wr && (sei_sel_e'(reg_sel) == SEI_SEL_ENABLE);
        set_vec = evt_pulse;
        if (ovf_pulse[0]) begin
            set_vec = set_vec | HF_MASK;
        end
        if (ovf_pulse[N_OVF-1]) begin
            set_vec = set_vec | VF_MASK;
        end
        clr_vec = flag_wr ? ~reg_wdata : '0;
    end

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        sei_flag_bit i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .clr_i  (clr_vec[g]),
            .flag_o (flags[g])
        );
    end

    sei_enable_reg #(.WIDTH(N_FLAGS)) i_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (en_wr),
        .data_i (reg_wdata),
        .en_o   (enables)
    );

    sei_irq_drive #(.WIDTH(N_FLAGS)) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .en_i    (enables),
        .irq_n_o (irq_n)
    );

    always_comb begin
        reg_rdata = (sei_sel_e'(reg_sel) == SEI_SEL_ENABLE) ? enables : flags;
    end

    assign flag_q_o = flags;

    p_ovf_h_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse[0] |=> flag_q_o[HF_IDX]);
    p_ovf_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse[N_OVF-1] |=> flag_q_o[VF_IDX]);
    p_enwr_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && evt_pulse == '0 && ovf_pulse == '0) |=> $stable(flag_q_o));
    p_en_no_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((flag_q_o & $past(evt_pulse)) == $past(evt_pulse)));
endmodule

// File: tb/test_sync_event_irq_ctrl.sv
module test_sync_event_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt_pulse = '0;
    logic [1:0] ovf_pulse = '0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [6:0] reg_wdata = '0;
    logic [6:0] reg_rdata;
    logic [6:0] flag_q_o;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sync_event_irq_ctrl i_sync_event_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .ovf_pulse(ovf_pulse),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .flag_q_o(flag_q_o), .irq_n(irq_n)
    );

    // row: [32] wr, [31] sel, [30:24] wdata, [23:17] evt, [16:15] ovf,
    //      [14:8] expected flags, [7:1] expected enables, [0] expected irq_n
    localparam int NV = 14;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0,1'b0,7'h00,7'h01,2'b00,7'h01,7'h00,1'b1}, // R2 event sets bit 0
        {1'b1,1'b1,7'h7F,7'h00,2'b00,7'h01,7'h7F,1'b1}, // R7 load enables, R9
        {1'b0,1'b0,7'h00,7'h00,2'b00,7'h01,7'h7F,1'b0}, // R8 irq low, R3 hold
        {1'b1,1'b0,7'h7F,7'h00,2'b00,7'h01,7'h7F,1'b0}, // R4 write 1 no effect
        {1'b1,1'b0,7'h7E,7'h00,2'b00,7'h00,7'h7F,1'b0}, // R4 write 0 clears
        {1'b0,1'b0,7'h00,7'h00,2'b00,7'h00,7'h7F,1'b1}, // R8 irq released
        {1'b0,1'b0,7'h00,7'h00,2'b01,7'h10,7'h7F,1'b1}, // R6 h overflow
        {1'b0,1'b0,7'h00,7'h40,2'b10,7'h70,7'h7F,1'b0}, // R6 v overflow + event
        {1'b1,1'b0,7'h00,7'h20,2'b00,7'h20,7'h7F,1'b0}, // R5 collision
        {1'b1,1'b1,7'h00,7'h00,2'b00,7'h20,7'h00,1'b0}, // R9 enables cleared
        {1'b0,1'b1,7'h00,7'h00,2'b00,7'h20,7'h00,1'b1}, // R8 masked
        {1'b0,1'b0,7'h00,7'h0E,2'b00,7'h2E,7'h00,1'b1}, // R7 set while disabled
        {1'b1,1'b1,7'h08,7'h00,2'b00,7'h2E,7'h08,1'b1}, // R7 single enable
        {1'b0,1'b1,7'h00,7'h00,2'b00,7'h2E,7'h08,1'b0}  // R8 late enable
    };

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 1'b0; evt_pulse = '0; ovf_pulse = '0; reg_wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_sel = 1'b0;
        check("R1 flags", flag_q_o, 7'h00);
        check("R1 irq_n", {6'd0, irq_n}, 7'h01);
        reg_sel = 1'b1; #1;
        check("R1 enables", reg_rdata, 7'h00);

        for (int i = 0; i < NV; i++) begin
            reg_wr    = VEC[i][32];
            reg_sel   = VEC[i][31];
            reg_wdata = VEC[i][30:24];
            evt_pulse = VEC[i][23:17];
            ovf_pulse = VEC[i][16:15];
            @(negedge clk);
            check($sformatf("R2/R4 row %0d flags", i), flag_q_o, VEC[i][14:8]);
            check($sformatf("R7/R9 row %0d readback", i), reg_rdata,
                  VEC[i][31] ? VEC[i][7:1] : VEC[i][14:8]);
            check($sformatf("R8 row %0d irq_n", i), {6'd0, irq_n}, {6'd0, VEC[i][0]});
        end
        idle();

        // R2 all events at once; R3 held over several idle cycles
        evt_pulse = 7'h7F; @(negedge clk); idle();
        repeat (5) @(negedge clk);
        check("R3 all flags held", flag_q_o, 7'h7F);
        reg_sel = 1'b0; #1;
        check("R2 readback flags", reg_rdata, 7'h7F);

        // R4 clear one flag in the middle
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 7'h77; @(negedge clk); idle();
        check("R4 clear bit 3 only", flag_q_o, 7'h77);

        // R9 enable write leaves flags
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 7'h55; @(negedge clk); idle();
        check("R9 flags after enable write", flag_q_o, 7'h77);
        check("R7 enables readback", reg_rdata, 7'h55);

        // R1 reset in mid-run
        rst_n = 1'b0; #1;
        check("R1 flags after reset", flag_q_o, 7'h00);
        check("R1 irq_n after reset", {6'd0, irq_n}, 7'h01);
        check("R1 enables after reset", reg_rdata, 7'h00);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule